// File: doc/BRIEF.md
# Instruction Alias Classifier

This block sits in front of a disassembler's text stage. It takes one 32-bit instruction word at a time from a small family of integer operations: bitwise OR with a shifted register, bitwise OR with an encoded immediate, add immediate, subtract with flag setting, hint, and extract from a register pair. For each word it returns a class code. The code names the preferred alias spelling when the operands form a known idiom and names the base operation otherwise. The block also returns the operand fields remapped to suit that spelling.

Register number 31 does not mean the same thing in every operation. For each of the destination and first-source fields, the block reports whether a 31 there stands for the stack pointer or for the zero register. Words arrive on a valid/ready handshake. The result appears on a registered output one cycle after the word is accepted, and it is held until the next accepted word.

Top module: `alias_classifier`

## Requirements
- R1: `in_ready` is low while `rst` is high and high on every cycle after reset. A word is accepted on a rising edge when `in_valid` and `in_ready` are both high. `out_valid` is high in exactly the cycle after an acceptance. After reset all outputs are zero.
- R2: Class codes are as follows. 0 unsupported, 1 OR-register, 2 MOV register, 3 OR-immediate, 4 MOV immediate, 5 ADD immediate, 6 MOV to/from SP, 7 SUBS, 8 CMP, 9 NOP, 10 named hint, 11 EXTR, 12 ROR. The fields are Rd = w[4:0], Rn = w[9:5] and Rm = w[20:16].
- R3: OR-register matches when w[30:24]=0101010 and w[21]=0. If Rn=31 and w[15:10]=0, the result is class 2 with rd=Rd, rn=Rm, rm=0 and imm=0. Otherwise the result is class 1 with rd, rn and rm taken from their fields and imm=w[15:10].
- R4: OR-immediate matches when w[30:23]=01100100. If Rn=31, the result is class 4 with rd=Rd, rn=0 and imm=w[22:10]. Otherwise the result is class 3 with rd=Rd, rn=Rn and imm=w[22:10]. rm is 0 in both cases.
- R5: ADD immediate matches when w[30:23]=00100010. If w[21:10]=0, w[22]=0 and either Rd=31 or Rn=31, the result is class 6 with rd=Rd, rn=Rn and imm=0. Otherwise the result is class 5 with rd=Rd, rn=Rn and imm=w[22:10].
- R6: For classes 5 and 6, both `out_rd_sp` and `out_rn_sp` are 1, meaning a 31 stands for the stack pointer. For every other class both are 0, meaning a 31 stands for the zero register.
- R7: SUBS matches when w[30:24]=1101011 and w[21]=0. If Rd=31, the result is class 8 with rd=0, rn=Rn, rm=Rm and imm=w[15:10]. Otherwise the result is class 7 with all three fields and imm=w[15:10].
- R8: A hint matches when w[31:12]=0xD5032 and w[4:0]=31. Its value is v=w[11:5], in the range 0 to 127. If 1 ≤ v ≤ 5, the result is class 10 with imm=v. For v=0 and for every other value, the result is class 9 with all operands 0.
- R9: EXTR matches when w[30:23]=00100111, w[21]=0 and w[22]=w[31]. If Rn=Rm, the result is class 12 with rd=Rd, rn=Rn, rm=0 and imm=w[15:10]. Otherwise the result is class 11 with all three fields and imm=w[15:10].
- R10: Any other word, including an EXTR pattern with w[22]≠w[31], gives class 0 with rd, rn, rm, imm and both SP flags all zero.
- R11: Between acceptances the output fields keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Result of the word accepted last cycle |
| out_class | output | 4 | Class code (R2) |
| out_rd | output | 5 | Remapped destination field |
| out_rn | output | 5 | Remapped first source field |
| out_rm | output | 5 | Remapped second source field |
| out_imm | output | 13 | Remapped immediate / shift / hint value |
| out_rd_sp | output | 1 | Destination 31 means stack pointer |
| out_rn_sp | output | 1 | First source 31 means stack pointer |

## Verification
The only state in the block is the ready flag and the result register. A fault in either shows at the ports in the cycle right after an acceptance. A stuck or late load gives a stale class or stale operands next to a fresh `out_valid`. A bad ready flag shows as `out_valid` missing, or as `out_valid` arriving while reset is held. Decode faults show the same cycle that the word's result appears. They appear as a wrong class on the idiom boundary cases: shift 0 against nonzero, immediate 0 with and without register 31, hint 5 against hint 6, and equal against unequal extract sources.

// File: rtl/alias_cls_pkg.sv
package alias_cls_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 13;
  localparam int HINT_W = 7;
  localparam int CLS_W  = 4;
  localparam logic [REG_W-1:0] REG31 = '1;

  typedef enum logic [CLS_W-1:0] {
    CLS_UNSUP   = 4'd0,
    CLS_ORR_REG = 4'd1,
    CLS_MOV_REG = 4'd2,
    CLS_ORR_IMM = 4'd3,
    CLS_MOV_IMM = 4'd4,
    CLS_ADD_IMM = 4'd5,
    CLS_MOV_SP  = 4'd6,
    CLS_SUBS    = 4'd7,
    CLS_CMP     = 4'd8,
    CLS_NOP     = 4'd9,
    CLS_HINT    = 4'd10,
    CLS_EXTR    = 4'd11,
    CLS_ROR     = 4'd12
  } alias_cls_e;

  typedef struct packed {
    alias_cls_e       cls;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rm;
    logic [IMM_W-1:0] imm;
    logic             rd_sp;
    logic             rn_sp;
  } alias_res_t;

  function automatic logic [REG_W-1:0] fld_rd(input logic [WORD_W-1:0] w);
    return w[4:0];
  endfunction

  function automatic logic [REG_W-1:0] fld_rn(input logic [WORD_W-1:0] w);
    return w[9:5];
  endfunction

  function automatic logic [REG_W-1:0] fld_rm(input logic [WORD_W-1:0] w);
    return w[20:16];
  endfunction

  function automatic logic [IMM_W-1:0] fld_six(input logic [WORD_W-1:0] w);
    return IMM_W'(w[15:10]);
  endfunction

  function automatic logic [IMM_W-1:0] fld_wide(input logic [WORD_W-1:0] w);
    return w[22:10];
  endfunction
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_cls_pkg::*;
#(
  parameter int NAMED_HINTS = 5
) (
  input  logic [WORD_W-1:0] word,
  output alias_res_t        res
);
  logic [REG_W-1:0]  rd, rn, rm;
  logic [HINT_W-1:0] hval;
  logic is_orr_reg, is_orr_imm, is_add_imm, is_subs, is_hint, is_extr;

  always_comb begin
    rd   = fld_rd(word);
    rn   = fld_rn(word);
    rm   = fld_rm(word);
    hval = word[11:5];
    is_orr_reg = (word[30:24] == 7'b0101010) && !word[21];
    is_orr_imm = (word[30:23] == 8'b01100100);
    is_add_imm = (word[30:23] == 8'b00100010);
    is_subs    = (word[30:24] == 7'b1101011) && !word[21];
    is_hint    = (word[31:12] == 20'hD5032) && (word[4:0] == REG31);
    is_extr    = (word[30:23] == 8'b00100111) && !word[21] && (word[22] == word[31]);
  end

  always_comb begin
    res = '0;
    if (is_orr_reg) begin
      if (rn == REG31 && word[15:10] == '0) begin
        res.cls = CLS_MOV_REG; res.rd = rd; res.rn = rm;
      end else begin
        res.cls = CLS_ORR_REG; res.rd = rd; res.rn = rn; res.rm = rm;
        res.imm = fld_six(word);
      end
    end else if (is_orr_imm) begin
      res.rd  = rd;
      res.imm = fld_wide(word);
      if (rn == REG31) res.cls = CLS_MOV_IMM;
      else begin
        res.cls = CLS_ORR_IMM; res.rn = rn;
      end
    end else if (is_add_imm) begin
      res.rd = rd; res.rn = rn; res.rd_sp = 1'b1; res.rn_sp = 1'b1;
      if (word[22:10] == '0 && (rd == REG31 || rn == REG31)) res.cls = CLS_MOV_SP;
      else begin
        res.cls = CLS_ADD_IMM; res.imm = fld_wide(word);
      end
    end else if (is_subs) begin
      res.rn = rn; res.rm = rm; res.imm = fld_six(word);
      if (rd == REG31) res.cls = CLS_CMP;
      else begin
        res.cls = CLS_SUBS; res.rd = rd;
      end
    end else if (is_hint) begin
      if (hval != '0 && int'(hval) <= NAMED_HINTS) begin
        res.cls = CLS_HINT; res.imm = IMM_W'(hval);
      end else res.cls = CLS_NOP;
    end else if (is_extr) begin
      res.rd = rd; res.rn = rn; res.imm = fld_six(word);
      if (rn == rm) res.cls = CLS_ROR;
      else begin
        res.cls = CLS_EXTR; res.rm = rm;
      end
    end
  end
endmodule

// File: rtl/alias_result_reg.sv
module alias_result_reg
  import alias_cls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  alias_res_t d,
  output alias_res_t q,
  output logic       valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/alias_classifier.sv
module alias_classifier
  import alias_cls_pkg::*;
#(
  parameter int NAMED_HINTS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [CLS_W-1:0]  out_class,
  output logic [REG_W-1:0]  out_rd,
  output logic [REG_W-1:0]  out_rn,
  output logic [REG_W-1:0]  out_rm,
  output logic [IMM_W-1:0]  out_imm,
  output logic              out_rd_sp,
  output logic              out_rn_sp
);
  logic       ready_q;
  logic       accept;
  alias_res_t dec_res;
  alias_res_t held_res;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  alias_decode #(.NAMED_HINTS(NAMED_HINTS)) u_dec (
    .word (in_word),
    .res  (dec_res)
  );

  alias_result_reg u_out (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .d     (dec_res),
    .q     (held_res),
    .valid (out_valid)
  );

  assign out_class = held_res.cls;
  assign out_rd    = held_res.rd;
  assign out_rn    = held_res.rn;
  assign out_rm    = held_res.rm;
  assign out_imm   = held_res.imm;
  assign out_rd_sp = held_res.rd_sp;
  assign out_rn_sp = held_res.rn_sp;
endmodule

module alias_classifier_chk
  import alias_cls_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             accept,
  input logic             in_ready,
  input logic             out_valid,
  input logic [CLS_W-1:0] out_class,
  input logic [REG_W-1:0] out_rd,
  input logic [REG_W-1:0] out_rn,
  input logic [REG_W-1:0] out_rm,
  input logic [IMM_W-1:0] out_imm,
  input logic             out_rd_sp,
  input logic             out_rn_sp
);
  // R1
  out_valid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    $past(accept) |-> out_valid);
  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ##1 in_ready);
  // R10
  unsup_zeroed_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_UNSUP) |->
      (out_rd == '0 && out_rn == '0 && out_rm == '0 && out_imm == '0 && !out_rd_sp && !out_rn_sp));
  // R8
  nop_zeroed_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_NOP) |->
      (out_rd == '0 && out_rn == '0 && out_rm == '0 && out_imm == '0));
  // R6
  sp_only_add_chk: assert property (@(posedge clk) disable iff (rst)
    (out_rd_sp || out_rn_sp) |-> (out_class == CLS_ADD_IMM || out_class == CLS_MOV_SP));
  // R7
  cmp_no_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_CMP) |-> out_rd == '0);
  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(out_class) && $stable(out_imm) && $stable(out_rd)));
endmodule

bind alias_classifier alias_classifier_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .accept    (accept),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_class (out_class),
  .out_rd    (out_rd),
  .out_rn    (out_rn),
  .out_rm    (out_rm),
  .out_imm   (out_imm),
  .out_rd_sp (out_rd_sp),
  .out_rn_sp (out_rn_sp)
);

// File: tb/alias_classifier_bench.sv
module alias_classifier_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready, out_valid, out_rd_sp, out_rn_sp;
  logic [3:0]  out_class;
  logic [4:0]  out_rd, out_rn, out_rm;
  logic [12:0] out_imm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alias_classifier u_alias_classifier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_class(out_class), .out_rd(out_rd), .out_rn(out_rn),
    .out_rm(out_rm), .out_imm(out_imm), .out_rd_sp(out_rd_sp), .out_rn_sp(out_rn_sp)
  );

  // expected packed as {cls4, rd5, rn5, rm5, imm13, rdsp, rnsp} = 34 bits
  function automatic logic [33:0] model(input logic [31:0] w);
    logic [4:0] d, n, m;
    logic [3:0] c;
    logic [4:0] od, on, om;
    logic [12:0] im;
    logic sp;
    d = w[4:0]; n = w[9:5]; m = w[20:16];
    c = 0; od = 0; on = 0; om = 0; im = 0; sp = 0;
    if ((w & 32'h7F20_0000) == 32'h2A00_0000) begin
      if (n == 31 && w[15:10] == 0) begin c = 2; od = d; on = m; end
      else begin c = 1; od = d; on = n; om = m; im = {7'd0, w[15:10]}; end
    end else if ((w & 32'h7F80_0000) == 32'h3200_0000) begin
      c = (n == 31) ? 4'd4 : 4'd3; od = d; on = (n == 31) ? 5'd0 : n; im = w[22:10];
    end else if ((w & 32'h7F80_0000) == 32'h1100_0000) begin
      sp = 1; od = d; on = n;
      if (w[22:10] == 0 && (d == 31 || n == 31)) c = 6;
      else begin c = 5; im = w[22:10]; end
    end else if ((w & 32'h7F20_0000) == 32'h6B00_0000) begin
      c = (d == 31) ? 4'd8 : 4'd7; od = (d == 31) ? 5'd0 : d; on = n; om = m; im = {7'd0, w[15:10]};
    end else if ((w & 32'hFFFF_F01F) == 32'hD503_201F) begin
      if (w[11:5] >= 1 && w[11:5] <= 5) begin c = 10; im = {6'd0, w[11:5]}; end
      else c = 9;
    end else if ((w & 32'h7FA0_0000) == 32'h1380_0000 && w[22] == w[31]) begin
      od = d; on = n; im = {7'd0, w[15:10]};
      if (n == m) c = 12; else begin c = 11; om = m; end
    end
    return {c, od, on, om, im, sp, sp};
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive word at negedge, check at the following negedge
  task automatic send(input logic [31:0] w);
    logic [33:0] e, a;
    e = model(w);
    in_valid = 1'b1; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    a = {out_class, out_rd, out_rn, out_rm, out_imm, out_rd_sp, out_rn_sp};
    check(out_valid === 1'b1, "R1", 64'(out_valid), 64'd1);
    check(a === e, req_of(e[33:30]), 64'(a), 64'(e));
    check({out_rd_sp, out_rn_sp} === e[1:0], "R6", 64'({out_rd_sp, out_rn_sp}), 64'(e[1:0]));
  endtask

  function automatic logic [31:0] shaped(input int k, input logic [31:0] r);
    case (k)
      0: return (r & ~32'h7F20_0000) | 32'h2A00_0000;
      1: return (r & ~32'h7F80_0000) | 32'h3200_0000;
      2: return (r & ~32'h7F80_0000) | 32'h1100_0000;
      3: return (r & ~32'h7F20_0000) | 32'h6B00_0000;
      4: return (r & ~32'hFFFF_F01F) | 32'hD503_201F;
      5: return (r & ~32'h7FA0_0000) | 32'h1380_0000;
      default: return r;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w;
    logic [33:0] held;
    void'($urandom(32'd1234));
    @(negedge clk);
    check(in_ready === 1'b0, "R1", 64'(in_ready), 64'd0);
    check(out_valid === 1'b0 && out_class === 4'd0 && out_imm === 13'd0, "R1",
          64'({out_valid, out_class, out_imm}), 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", 64'(in_ready), 64'd1);

    // R3 corners
    send(32'hAA0303E1);            // Rn=31 shift 0 -> MOV reg
    send(32'hAA030BE1);            // Rn=31 shift 2 -> OR
    // R4 corners
    send(32'hB24003E2);            // Rn=31 -> MOV imm
    send(32'hB2400042);            // Rn=2 -> OR imm
    // R5 corners
    send(32'h910003FF);            // imm0 Rd=31 Rn=31
    send(32'h91000041);            // imm0 no 31 -> ADD
    send(32'h910007E1);            // imm1 Rn=31 -> ADD
    send(32'h914003E1);            // shifted zero, Rn=31 -> ADD
    // R7 corners
    send(32'hEB02003F);            // Rd=31 -> CMP
    send(32'hEB020021);            // SUBS
    // R8 corners
    send(32'hD503201F);            // hint 0 NOP
    send(32'hD50320BF);            // hint 5 named
    send(32'hD50320DF);            // hint 6 NOP
    send(32'hD5032FFF);            // hint 127 NOP
    // R9 corners
    send(32'h93C21041);            // Rn=Rm=2 -> ROR
    send(32'h93C31041);            // EXTR
    send(32'h13C21041);            // N != sf -> unsupported
    // R10
    send(32'h00000000);
    send(32'hFFFFFFFF);

    // R11: idle cycles hold result, out_valid drops
    held = {out_class, out_rd, out_rn, out_rm, out_imm, out_rd_sp, out_rn_sp};
    in_word = 32'hAA0303E1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);
    check({out_class, out_rd, out_rn, out_rm, out_imm, out_rd_sp, out_rn_sp} === held, "R11",
          64'({out_class, out_rd, out_rn, out_rm, out_imm, out_rd_sp, out_rn_sp}), 64'(held));

    // R2 random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom % 7);
      w = shaped(k, $urandom);
      if (($urandom % 3) == 0) w[9:5] = 5'd31;
      if (($urandom % 3) == 0) w[4:0] = 5'd31;
      if (($urandom % 4) == 0) w[15:10] = 6'd0;
      if (k == 5 && ($urandom % 2) == 0) w[20:16] = w[9:5];
      if (k == 2 && ($urandom % 2) == 0) w[22:10] = 13'd0;
      if (k == 4 && ($urandom % 2) == 0) w[11:5] = 7'($urandom % 8);
      send(w);
      if (($urandom % 5) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule